// File: doc/BRIEF.md
# Protected Microsecond Time-of-Day Counter

This block keeps a 52-bit binary time value that counts microseconds without pause. A parameterised divider turns the core clock into a one-cycle advance pulse every `DIV` cycles, and the counter steps by one on each pulse. The counter never stops for processor state. Reset is the only thing that clears it. When the count passes its largest value it rolls over to zero.

Software reads the value through a store port and writes it through a set port. A store returns a 64-bit doubleword: the count sits in the upper 52 bits and the lower 12 bits are zero. The store also returns a condition code that says whether the value can be trusted. A set is honoured only when two inputs are both high: the requester's supervisor-state flag and an external key switch. A set that is honoured reloads the count and marks it valid. A set that fails either test leaves everything as it was and reports a rejected status.

The value becomes untrustworthy when any of the following happens: diagnostic mode is entered, an external error is reported, or an internal parity check over the count finds a mismatch. It stays untrustworthy until the next accepted set. The store port uses a valid/ready request and a valid/ready response with a single response slot. A new request is taken only when that slot is empty or is being emptied in the same cycle. A response that is held back by a low `st_rsp_ready` keeps its data and code unchanged. The set port is always ready. Its outcome appears as a one-cycle `set_done` pulse in the cycle after the handshake.

Top module: `tod_clock_unit`

## Requirements
- R1: The count advances by exactly one for every `DIV` core clock cycles, whatever the state of `diag_mode`, `hw_err` or the valid flag. So two stores captured k·`DIV` cycles apart differ by exactly k.
- R2: A store response carries the count in bits 63:12 and zero in bits 11:0. The count is the one held in the cycle of the request handshake. After an accepted set, a store whose handshake is in the very next cycle returns exactly the loaded value.
- R3: Once the count reaches all ones, the next advance makes it zero.
- R4: A set is accepted only when `set_priv` and `set_key` are both 1. If either is 0, `set_done` pulses with `set_cc` = 2 and both the count and the valid flag stay unchanged.
- R5: An accepted set loads `set_data[63:12]` into the count and ignores `set_data[11:0]`. It marks the value valid, and `set_done` pulses one cycle after the handshake with `set_cc` = 0.
- R6: After reset the value is invalid. A store returns condition code 1 when the value is invalid and 0 when it is valid.
- R7: While `diag_mode` or `hw_err` is high, or while the internal parity check fails, the value becomes invalid from the next cycle. It stays invalid until an accepted set arrives in a cycle with no such condition. In a cycle where both happen, the invalidation wins over a set, but the set still loads the count.
- R8: While `st_rsp_valid` is high and `st_rsp_ready` is low, `st_req_ready` is 0 and the response data and code hold steady. A response that is accepted by the consumer with no new request drops `st_rsp_valid` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | Set request present |
| set_ready | output | 1 | Set port ready (always 1) |
| set_data | input | 64 | New doubleword value; bits 11:0 ignored |
| set_priv | input | 1 | Requester is in supervisor state |
| set_key | input | 1 | Security key switch in the enable position |
| set_done | output | 1 | One-cycle pulse: set outcome available |
| set_cc | output | 2 | Set outcome: 0 accepted, 2 rejected |
| st_req_valid | input | 1 | Store request present |
| st_req_ready | output | 1 | Store request can be taken |
| st_rsp_valid | output | 1 | Store response present |
| st_rsp_ready | input | 1 | Consumer takes the store response |
| st_rsp_data | output | 64 | Captured doubleword |
| st_rsp_cc | output | 2 | Store code: 0 valid, 1 invalid |
| diag_mode | input | 1 | Diagnostic mode; invalidates the value |
| hw_err | input | 1 | External error report; invalidates the value |

## Verification
A counter that skips or repeats an advance shows up as a wrong difference between two stores taken a known number of whole divider periods apart. It is visible at the first such pair. A valid flag that is lost, or that comes back when it should not, shows in the condition code of the very next store. The bench takes a store straight after each set, rejected set, diagnostic pulse and error pulse. A broken response slot shows within one cycle as moving data or a ready that is asserted while a response is being held back.

// File: rtl/tod_pkg.sv
package tod_pkg;

  typedef enum logic [1:0] {
    CC_OK      = 2'd0,
    CC_INVALID = 2'd1,
    CC_REJECT  = 2'd2
  } tod_cc_e;

  localparam int TOD_CNT_W_DEF = 52;
  localparam int TOD_DW_W_DEF  = 64;

endpackage

// File: rtl/tod_tick_div.sv
module tod_tick_div #(
  parameter int DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  generate
    if (DIV > 1) begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] div_q;

      assign tick = (div_q == CW'(DIV - 1));

      always_ff @(posedge clk) begin
        if (!rst_n)    div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + CW'(1);
      end

      // R1: advance pulses are isolated single cycles
      a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/tod_count_core.sv
module tod_count_core #(
  parameter int CNT_W = 52
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             set_fire,
  input  logic             set_allow,
  input  logic [CNT_W-1:0] set_val,
  input  logic             diag_mode,
  input  logic             hw_err,
  output logic [CNT_W-1:0] cnt,
  output logic             valid
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             par_q, valid_q;
  logic             load, par_err, kill;

  assign load    = set_fire & set_allow;
  assign par_err = (^cnt_q) != par_q;
  assign kill    = diag_mode | hw_err | par_err;

  always_comb begin
    if (load)      cnt_n = set_val;
    else if (tick) cnt_n = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    else           cnt_n = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      par_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      par_q <= ^cnt_n;
      if (kill)      valid_q <= 1'b0;
      else if (load) valid_q <= 1'b1;
    end
  end

  assign cnt   = cnt_q;
  assign valid = valid_q;

  // R4: a refused set leaves the count alone
  a_r4_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (set_fire && !set_allow && !tick) |=> (cnt_q == $past(cnt_q)));
  // R3: roll over from all ones
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == {CNT_W{1'b1}} && tick && !load) |=> (cnt_q == '0));
  // R7: invalidation sources clear the flag
  a_r7_diag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_mode || hw_err) |=> !valid_q);
  // R5: clean accepted set restores validity
  a_r5_set_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !diag_mode && !hw_err && !par_err) |=> valid_q);
  // R5: validity rises only through an accepted set
  a_r5_rise_by_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(load));

endmodule

// File: rtl/tod_store_port.sv
module tod_store_port
  import tod_pkg::*;
#(
  parameter int CNT_W = 52,
  parameter int DW_W  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             valid,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW_W-1:0]  rsp_data,
  output logic [1:0]       rsp_cc
);

  localparam int LOW_W = DW_W - CNT_W;

  logic            rv_q;
  logic [DW_W-1:0] data_q;
  tod_cc_e         cc_q;
  logic            fire;

  assign req_ready = !rv_q || rsp_ready;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q   <= 1'b0;
      data_q <= '0;
      cc_q   <= CC_INVALID;
    end else if (fire) begin
      rv_q   <= 1'b1;
      data_q <= {cnt, {LOW_W{1'b0}}};
      cc_q   <= valid ? CC_OK : CC_INVALID;
    end else if (rsp_ready) begin
      rv_q <= 1'b0;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_data  = data_q;
  assign rsp_cc    = cc_q;

  // R8: held response stays put
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rv_q && !rsp_ready) |=> (rv_q && $stable(data_q) && $stable(cc_q)));
  // R2: low-order bits of every response are zero
  a_r2_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q |-> (data_q[LOW_W-1:0] == '0));

endmodule

// File: rtl/tod_clock_unit.sv
module tod_clock_unit
  import tod_pkg::*;
#(
  parameter int CNT_W = TOD_CNT_W_DEF,
  parameter int DW_W  = TOD_DW_W_DEF,
  parameter int DIV   = 200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_valid,
  output logic            set_ready,
  input  logic [DW_W-1:0] set_data,
  input  logic            set_priv,
  input  logic            set_key,
  output logic            set_done,
  output logic [1:0]      set_cc,
  input  logic            st_req_valid,
  output logic            st_req_ready,
  output logic            st_rsp_valid,
  input  logic            st_rsp_ready,
  output logic [DW_W-1:0] st_rsp_data,
  output logic [1:0]      st_rsp_cc,
  input  logic            diag_mode,
  input  logic            hw_err
);

  localparam int LOW_W = DW_W - CNT_W;

  logic             tick;
  logic             set_fire, set_allow;
  logic [CNT_W-1:0] cnt;
  logic             valid;
  logic             done_q;
  tod_cc_e          scc_q;
  logic             unused_low_bits;

  assign set_ready       = 1'b1;
  assign set_fire        = set_valid;
  assign set_allow       = set_priv & set_key;
  assign unused_low_bits = ^set_data[LOW_W-1:0];

  tod_tick_div #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  tod_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .set_fire (set_fire),
    .set_allow(set_allow),
    .set_val  (set_data[DW_W-1:LOW_W]),
    .diag_mode(diag_mode),
    .hw_err   (hw_err),
    .cnt      (cnt),
    .valid    (valid)
  );

  tod_store_port #(.CNT_W(CNT_W), .DW_W(DW_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (cnt),
    .valid    (valid),
    .req_valid(st_req_valid),
    .req_ready(st_req_ready),
    .rsp_valid(st_rsp_valid),
    .rsp_ready(st_rsp_ready),
    .rsp_data (st_rsp_data),
    .rsp_cc   (st_rsp_cc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      scc_q  <= CC_OK;
    end else begin
      done_q <= set_fire;
      if (set_fire) scc_q <= set_allow ? CC_OK : CC_REJECT;
    end
  end

  assign set_done = done_q;
  assign set_cc   = scc_q;

  // R4: set outcome pulse follows each handshake
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    set_fire |=> (done_q && scc_q == ($past(set_allow) ? CC_OK : CC_REJECT)));

endmodule

// File: tb/tod_clock_unit_bench.sv
module tod_clock_unit_bench;

  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        set_valid = 1'b0;
  logic        set_ready;
  logic [63:0] set_data = '0;
  logic        set_priv = 1'b0;
  logic        set_key = 1'b0;
  logic        set_done;
  logic [1:0]  set_cc;
  logic        st_req_valid = 1'b0;
  logic        st_req_ready;
  logic        st_rsp_valid;
  logic        st_rsp_ready = 1'b1;
  logic [63:0] st_rsp_data;
  logic [1:0]  st_rsp_cc;
  logic        diag_mode = 1'b0;
  logic        hw_err = 1'b0;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  tod_clock_unit #(.DIV(DIV)) u_tod_clock_unit (
    .clk(clk), .rst_n(rst_n),
    .set_valid(set_valid), .set_ready(set_ready), .set_data(set_data),
    .set_priv(set_priv), .set_key(set_key), .set_done(set_done), .set_cc(set_cc),
    .st_req_valid(st_req_valid), .st_req_ready(st_req_ready),
    .st_rsp_valid(st_rsp_valid), .st_rsp_ready(st_rsp_ready),
    .st_rsp_data(st_rsp_data), .st_rsp_cc(st_rsp_cc),
    .diag_mode(diag_mode), .hw_err(hw_err)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // starts and ends at a falling edge
  task automatic do_set(input logic [51:0] v, input logic [11:0] lo,
                        input bit pr, input bit ky, output logic [1:0] cc);
    set_data  = {v, lo};
    set_priv  = pr;
    set_key   = ky;
    set_valid = 1'b1;
    @(negedge clk);
    set_valid = 1'b0;
    check(set_done === 1'b1, "R4 set_done pulse", {63'd0, set_done}, 64'd1);
    cc = set_cc;
  endtask

  task automatic do_store(output logic [63:0] d, output logic [1:0] cc);
    st_rsp_ready = 1'b1;
    st_req_valid = 1'b1;
    @(negedge clk);
    st_req_valid = 1'b0;
    check(st_rsp_valid === 1'b1, "R8 response valid", {63'd0, st_rsp_valid}, 64'd1);
    d  = st_rsp_data;
    cc = st_rsp_cc;
  endtask

  task automatic t_reset();
    logic [63:0] d; logic [1:0] cc;
    check(st_rsp_valid === 1'b0, "R8 no response after reset", {63'd0, st_rsp_valid}, 64'd0);
    do_store(d, cc);
    check(cc == 2'd1, "R6 invalid after reset", {62'd0, cc}, 64'd1);
  endtask

  task automatic t_reject_while_invalid();
    logic [63:0] d; logic [1:0] cc;
    do_set(52'h0_0000_1111_2222, 12'h0, 1'b1, 1'b0, cc);
    check(cc == 2'd2, "R4 key off rejected", {62'd0, cc}, 64'd2);
    do_store(d, cc);
    check(cc == 2'd1, "R4 rejected set keeps invalid", {62'd0, cc}, 64'd1);
  endtask

  task automatic t_accept();
    logic [63:0] d; logic [1:0] cc;
    logic [51:0] v = 52'h1_2345_6789_ABCD;
    do_set(v, 12'hABC, 1'b1, 1'b1, cc);
    check(cc == 2'd0, "R5 set accepted", {62'd0, cc}, 64'd0);
    do_store(d, cc);
    check(d == {v, 12'h000}, "R2 R5 exact loaded value, low bits zero", d, {v, 12'h000});
    check(cc == 2'd0, "R6 valid after set", {62'd0, cc}, 64'd0);
  endtask

  task automatic t_reject_valid();
    logic [63:0] d; logic [1:0] cc;
    logic [51:0] v = 52'h0_0000_0000_4000;
    do_set(v, 12'h0, 1'b1, 1'b1, cc);
    do_set(52'hF_0000_0000_0000, 12'h0, 1'b0, 1'b1, cc);
    check(cc == 2'd2, "R4 unprivileged rejected", {62'd0, cc}, 64'd2);
    do_store(d, cc);
    check(d[63:12] == v || d[63:12] == v + 1, "R4 count untouched by rejected set",
          d, {v, 12'h000});
    check(cc == 2'd0, "R4 valid kept after rejected set", {62'd0, cc}, 64'd0);
  endtask

  task automatic t_rate(input int k);
    logic [63:0] d1, d2; logic [1:0] cc;
    do_store(d1, cc);
    repeat (k * DIV - 1) @(negedge clk);
    do_store(d2, cc);
    check(d2[63:12] - d1[63:12] == 52'(k), "R1 advance rate",
          {12'd0, d2[63:12] - d1[63:12]}, 64'(k));
  endtask

  task automatic t_wrap();
    logic [63:0] d; logic [1:0] cc;
    do_set({52{1'b1}}, 12'h0, 1'b1, 1'b1, cc);
    repeat (DIV) @(negedge clk);
    do_store(d, cc);
    check(d == 64'd0, "R3 rollover to zero", d, 64'd0);
  endtask

  task automatic t_invalidate(input bit use_diag);
    logic [63:0] d1, d2; logic [1:0] cc;
    do_set(52'h0_0000_0000_0100, 12'h0, 1'b1, 1'b1, cc);
    if (use_diag) diag_mode = 1'b1; else hw_err = 1'b1;
    @(negedge clk);
    diag_mode = 1'b0; hw_err = 1'b0;
    do_store(d1, cc);
    check(cc == 2'd1, use_diag ? "R7 diag invalidates" : "R7 error invalidates",
          {62'd0, cc}, 64'd1);
    repeat (2 * DIV - 1) @(negedge clk);
    do_store(d2, cc);
    check(d2[63:12] - d1[63:12] == 52'd2, "R1 counts while invalid",
          {12'd0, d2[63:12] - d1[63:12]}, 64'd2);
    check(cc == 2'd1, "R7 stays invalid", {62'd0, cc}, 64'd1);
  endtask

  task automatic t_set_during_diag();
    logic [63:0] d; logic [1:0] cc;
    logic [51:0] v = 52'h0_0000_0000_7777;
    diag_mode = 1'b1;
    do_set(v, 12'h0, 1'b1, 1'b1, cc);
    diag_mode = 1'b0;
    do_store(d, cc);
    check(cc == 2'd1, "R7 invalidation wins over set", {62'd0, cc}, 64'd1);
    check(d[63:12] == v, "R7 set still loads count", d, {v, 12'h000});
    do_set(v, 12'h0, 1'b1, 1'b1, cc);
    do_store(d, cc);
    check(cc == 2'd0, "R7 later clean set revalidates", {62'd0, cc}, 64'd0);
  endtask

  task automatic t_backpressure();
    logic [63:0] held; logic [1:0] hcc;
    st_rsp_ready = 1'b0;
    st_req_valid = 1'b1;
    @(negedge clk);
    held = st_rsp_data; hcc = st_rsp_cc;
    check(st_rsp_valid === 1'b1, "R8 response appears", {63'd0, st_rsp_valid}, 64'd1);
    for (int i = 0; i < 3; i++) begin
      check(st_req_ready === 1'b0, "R8 request blocked while held",
            {63'd0, st_req_ready}, 64'd0);
      @(negedge clk);
      check(st_rsp_data == held && st_rsp_cc == hcc && st_rsp_valid === 1'b1,
            "R8 held response stable", st_rsp_data, held);
    end
    st_req_valid = 1'b0;
    st_rsp_ready = 1'b1;
    @(negedge clk);
    check(st_rsp_valid === 1'b0, "R8 drained response drops", {63'd0, st_rsp_valid}, 64'd0);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(set_ready === 1'b1, "R4 set port ready", {63'd0, set_ready}, 64'd1);
    t_reset();
    t_reject_while_invalid();
    t_accept();
    t_reject_valid();
    t_rate(1);
    t_rate(5);
    t_wrap();
    t_invalidate(1'b1);
    t_invalidate(1'b0);
    t_set_during_diag();
    t_backpressure();
    t_rate(3);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule